// File: doc/BRIEF.md
# Master-Clock Frame Timing Generator

This block derives per-sample timing from a master clock that runs at a fixed multiple of the audio sample rate. A select input picks 256 or 384 master-clock cycles per sample period. The block follows an external left/right frame clock, which has the same frequency as the sample rate but an arbitrary phase, and keeps a phase counter aligned to it.

The frame clock passes through a synchronizer into the master-clock domain. Each synchronized rising edge marks the start of a sample period. When the block is searching, the first edge sets the counter to phase 0, asserts the lock indication and raises a one-cycle resync pulse.

While locked, every edge must arrive when the counter is at its last value, so that the edge and the counter wrap fall together. An edge that arrives early, or a wrap that comes with no edge, drops the lock. The block then waits for the next edge to realign. The converters downstream use a sample strobe, which is high at phase 0 while locked.

Two run-enable inputs, one for the converter in each direction, gate the block. With both low, the block idles.

Top module: `ftg_frame_timer`

## Requirements
- R1: After synchronous reset, `locked`, `sample_strobe` and `resync` are 0 and `phase` is 0, and they stay so until a frame-clock rising edge is seen.
- R2: With `ratio_sel` = 0 and aligned frames of 256 cycles, `phase` counts 0 to 255 and wraps, giving one `sample_strobe` every 256 cycles.
- R3: With `ratio_sel` = 1 and aligned frames of 384 cycles, `phase` counts 0 to 383 and wraps, giving one `sample_strobe` every 384 cycles.
- R4: When searching, a frame-clock rise that is set up before master-clock edge k gives `locked` = 1, `phase` = 0 and `sample_strobe` = 1 after edge k+2.
- R5: `resync` is high for exactly one cycle, and only on entry into lock, in the same cycle as the first strobe.
- R6: While locked, a frame-clock rise that arrives before the counter reaches its last value drops `locked` without a strobe. The next rise relocks, with `resync`.
- R7: While locked, if the counter reaches its last value with no frame-clock rise, `locked` drops on the following edge. A later rise relocks, with `resync`.
- R8: `sample_strobe` only appears while locked, and while not locked `phase` holds at 0.
- R9: With `adc_en` and `dac_en` both low, the block forces `locked` = 0 and `phase` = 0, gives no strobe and ignores the frame clock. Either enable high on its own lets the block run.
- R10: While every frame lasts exactly one sample period, lock is kept, a strobe follows each rise after the same latency as in R4, and `resync` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| ratio_sel | input | 1 | 0: 256 cycles per sample, 1: 384 cycles per sample |
| adc_en | input | 1 | Run enable of the capture converter |
| dac_en | input | 1 | Run enable of the playback converter |
| frame_clk | input | 1 | External left/right frame clock, asynchronous in phase |
| sample_strobe | output | 1 | One-cycle pulse at phase 0 while locked |
| phase | output | 9 | Position inside the sample period |
| locked | output | 1 | Counter is aligned to the frame clock |
| resync | output | 1 | One-cycle pulse when lock is (re)acquired |

## Verification
The frame clock is driven with periods equal to, shorter than and longer than the selected ratio, in both ratio modes. Equal periods show that lock is kept and the strobe is spaced correctly. Short periods show that an early edge is detected. Long periods show that a missing edge is detected by timeout, and that recovery raises a fresh resync. Frames sent while both enables are low, followed by a restart on one enable only, separate gating from misalignment. A 256-cycle frame sent in 384 mode proves that the ratio input, and not the frame clock, sets the expected period.

// File: rtl/ftg_pkg.sv
package ftg_pkg;

    localparam int unsigned DEF_RATIO_LO = 256;
    localparam int unsigned DEF_RATIO_HI = 384;

    typedef enum logic {
        ST_SEARCH = 1'b0,
        ST_LOCKED = 1'b1
    } lock_state_e;

    typedef struct packed {
        logic rise;
        logic at_last;
    } frame_evt_t;

    function automatic int unsigned last_count(input logic sel,
                                               input int unsigned lo,
                                               input int unsigned hi);
        return (sel ? hi : lo) - 1;
    endfunction

endpackage

// File: rtl/ftg_edge_sync.sv
module ftg_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= async_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[STAGES-2:0], async_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q[STAGES-1];
    end

    assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/ftg_phase_ctr.sv
module ftg_phase_ctr #(
    parameter int PHASE_W = 9
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_zero,
    input  logic [PHASE_W-1:0] last_val,
    output logic [PHASE_W-1:0] phase_o,
    output logic               at_last_o
);
    logic [PHASE_W-1:0] phase_q;

    assign at_last_o = (phase_q >= last_val);

    always_ff @(posedge clk) begin
        if (rst)            phase_q <= '0;
        else if (load_zero) phase_q <= '0;
        else if (at_last_o) phase_q <= '0;
        else                phase_q <= phase_q + 1'b1;
    end

    assign phase_o = phase_q;
endmodule

// File: rtl/ftg_lock_ctrl.sv
module ftg_lock_ctrl
    import ftg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        active,
    input  frame_evt_t  evt,
    output lock_state_e state_o,
    output logic        resync_o,
    output logic        load_zero_o
);
    lock_state_e state_q, state_d;
    logic        resync_q, resync_d;
    logic        misalign;

    assign misalign = evt.rise ^ evt.at_last;

    always_comb begin
        state_d  = state_q;
        resync_d = 1'b0;
        if (!active) begin
            state_d = ST_SEARCH;
        end else begin
            case (state_q)
                ST_SEARCH: begin
                    if (evt.rise) begin
                        state_d  = ST_LOCKED;
                        resync_d = 1'b1;
                    end
                end
                ST_LOCKED: begin
                    if (misalign) state_d = ST_SEARCH;
                end
                default: state_d = ST_SEARCH;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_SEARCH;
            resync_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            resync_q <= resync_d;
        end
    end

    assign load_zero_o = !active || (state_q == ST_SEARCH) || misalign;
    assign state_o     = state_q;
    assign resync_o    = resync_q;
endmodule

// File: rtl/ftg_frame_timer.sv
module ftg_frame_timer
    import ftg_pkg::*;
#(
    parameter int unsigned RATIO_LO    = DEF_RATIO_LO,
    parameter int unsigned RATIO_HI    = DEF_RATIO_HI,
    parameter int          SYNC_STAGES = 2,
    localparam int         PHASE_W     = $clog2(RATIO_HI)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ratio_sel,
    input  logic               adc_en,
    input  logic               dac_en,
    input  logic               frame_clk,
    output logic               sample_strobe,
    output logic [PHASE_W-1:0] phase,
    output logic               locked,
    output logic               resync
);
    logic               rise;
    logic               at_last;
    logic               load_zero;
    logic               active;
    logic [PHASE_W-1:0] last_val;
    logic [PHASE_W-1:0] phase_q;
    lock_state_e        state;
    frame_evt_t         evt;

    assign active   = adc_en | dac_en;
    assign last_val = PHASE_W'(last_count(ratio_sel, RATIO_LO, RATIO_HI));

    ftg_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (frame_clk),
        .rise_o   (rise)
    );

    ftg_phase_ctr #(.PHASE_W(PHASE_W)) i_ctr (
        .clk       (clk),
        .rst       (rst),
        .load_zero (load_zero),
        .last_val  (last_val),
        .phase_o   (phase_q),
        .at_last_o (at_last)
    );

    assign evt.rise    = rise;
    assign evt.at_last = at_last;

    ftg_lock_ctrl i_lock (
        .clk         (clk),
        .rst         (rst),
        .active      (active),
        .evt         (evt),
        .state_o     (state),
        .resync_o    (resync),
        .load_zero_o (load_zero)
    );

    assign locked        = (state == ST_LOCKED);
    assign phase         = phase_q;
    assign sample_strobe = locked && (phase_q == '0);
endmodule

// File: rtl/ftg_checker.sv
module ftg_checker #(
    parameter int unsigned RATIO_LO = 256,
    parameter int          PHASE_W  = 9
) (
    input logic               clk,
    input logic               rst,
    input logic               ratio_sel,
    input logic               adc_en,
    input logic               dac_en,
    input logic               sample_strobe,
    input logic [PHASE_W-1:0] phase,
    input logic               locked,
    input logic               resync
);
    AST_RESYNC_SINGLE: assert property (@(posedge clk) disable iff (rst)
        resync |=> !resync); // R5

    AST_LOCK_ENTRY: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> resync); // R5

    AST_PHASE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        locked |=> (!locked || phase == '0 || phase == $past(phase) + 1'b1)); // R2

    AST_HIGH_RATIO_ONLY: assert property (@(posedge clk) disable iff (rst)
        (locked && phase > PHASE_W'(RATIO_LO - 1)) |-> $past(ratio_sel)); // R3

    AST_SEARCH_ZERO: assert property (@(posedge clk) disable iff (rst)
        !locked |-> (phase == '0 && !sample_strobe)); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(adc_en || dac_en) |=> (!locked && phase == '0 && !resync)); // R9
endmodule

bind ftg_frame_timer ftg_checker #(
    .RATIO_LO (RATIO_LO),
    .PHASE_W  (PHASE_W)
) i_chk (
    .clk           (clk),
    .rst           (rst),
    .ratio_sel     (ratio_sel),
    .adc_en        (adc_en),
    .dac_en        (dac_en),
    .sample_strobe (sample_strobe),
    .phase         (phase),
    .locked        (locked),
    .resync        (resync)
);

// File: tb/test_ftg_frame_timer.sv
module test_ftg_frame_timer;
    logic       clk = 1'b0;
    logic       rst, ratio_sel, adc_en, dac_en, frame_clk;
    logic       sample_strobe, locked, resync;
    logic [8:0] phase;

    always #5 clk = ~clk;

    ftg_frame_timer i_ftg_frame_timer (
        .clk           (clk),
        .rst           (rst),
        .ratio_sel     (ratio_sel),
        .adc_en        (adc_en),
        .dac_en        (dac_en),
        .frame_clk     (frame_clk),
        .sample_strobe (sample_strobe),
        .phase         (phase),
        .locked        (locked),
        .resync        (resync)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int errors = 0;
    int checks = 0;

    typedef struct { int at; bit rs; } exp_t;
    exp_t q[$];

    bit m_locked  = 1'b0;
    int last_rise = -1;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Scoreboard monitor: every strobe/resync event must match the queue head
    always @(negedge clk) begin
        if (!rst && (sample_strobe || resync)) begin
            if (q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R8 unexpected event: strobe=%0d resync=%0d expected none (cycle %0d)",
                         sample_strobe, resync, cyc);
            end else begin
                exp_t e;
                e = q.pop_front();
                check("R4 R10 event cycle", cyc, e.at);
                check("R5 resync flag", int'(resync), int'(e.rs));
                check("R2 strobe with event", int'(sample_strobe), 1);
            end
        end
    end

    // One frame of length len; optional mid-frame check at offset off
    task automatic frame(input int len, input int off, input int exp_lock,
                         input int exp_phase, input string req);
        int c;
        int g;
        int per;
        @(negedge clk);
        c = cyc;
        frame_clk = 1'b1;
        g = c - last_rise;
        last_rise = c;
        per = ratio_sel ? 384 : 256;
        if (!(adc_en || dac_en)) begin
            m_locked = 1'b0;
        end else if (!m_locked) begin
            q.push_back('{at: c + 3, rs: 1'b1});
            m_locked = 1'b1;
        end else if (g == per) begin
            q.push_back('{at: c + 3, rs: 1'b0});
        end else if (g > per) begin
            q.push_back('{at: c + 3, rs: 1'b1});
        end else begin
            m_locked = 1'b0;
        end
        for (int i = 1; i < len; i++) begin
            @(negedge clk);
            if (i == len / 2) frame_clk = 1'b0;
            if (i == off) begin
                check({req, " locked"}, int'(locked), exp_lock);
                if (exp_phase >= 0) check({req, " phase"}, int'(phase), exp_phase);
            end
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; ratio_sel = 1'b0; adc_en = 1'b1; dac_en = 1'b1; frame_clk = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (6) @(negedge clk);
        // R1 reset state
        check("R1 locked", int'(locked), 0);
        check("R1 strobe", int'(sample_strobe), 0);
        check("R1 resync", int'(resync), 0);
        check("R1 phase", int'(phase), 0);

        // R4 first lock, R2 and R10 steady 256 mode
        frame(256, 10, 1, 7, "R4");
        for (int k = 0; k < 3; k++) frame(256, 200, 1, 197, "R2");
        frame(256, 255, 1, 252, "R10");

        // R6 early edge: 200-cycle frame, next rise is early
        frame(200, -1, 0, -1, "R6");
        frame(256, 10, 0, 0, "R6");
        frame(256, 10, 1, 7, "R6 relock");
        frame(256, 100, 1, 97, "R10");

        // R7 missing edge: 300-cycle frame times out at offset 259
        frame(300, 280, 0, 0, "R7");
        frame(256, 10, 1, 7, "R7 relock");
        frame(256, 50, 1, 47, "R10");

        // R9 power down: frames ignored
        adc_en = 1'b0; dac_en = 1'b0;
        frame(256, 10, 0, 0, "R9");
        frame(256, 128, 0, 0, "R9");
        ratio_sel = 1'b1;
        dac_en = 1'b1;

        // R3 384 mode, single enable
        frame(384, 10, 1, 7, "R9 single enable");
        for (int k = 0; k < 3; k++) frame(384, 300, 1, 297, "R3");

        // R3 256-cycle frame is early in 384 mode
        frame(256, -1, 0, -1, "R3");
        frame(384, 10, 0, 0, "R3 early");
        frame(384, 10, 1, 7, "R3 relock");
        frame(384, 383, 1, 380, "R3");

        // Frame clock stops: timeout drops lock
        repeat (600) @(negedge clk);
        check("R7 lock after stop", int'(locked), 0);
        check("R5 pending events", q.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule